// File: doc/BRIEF.md
# Peripheral Reset Register Bank

This block keeps the reset lines of up to ninety-six on-chip peripherals. They are held in three 32-bit control registers. A 1 in a bit holds the matching peripheral in reset, and every bit drives its own output line. A processor reads and writes whole registers over a simple memory-mapped bus. A second, line-oriented command port works on one line at a time. It takes a 16-bit line identifier and sets, clears or reports that single bit without disturbing its neighbours.

A write-only software-reset register on the same bus raises one of four system reset requests. The request that fires is selected by the single bit set in the written word.

The command port runs a two-state controller. In `CS_IDLE` it shows ready. An accepted command moves it to `CS_APPLY` (transition *accept*). In `CS_APPLY` the addressed bit is updated and the reply is registered, and the controller always returns to `CS_IDLE` on the next edge (transition *retire*). Each register also has its own update logic, which merges a command-port change into a bus write that lands on the same register in the same cycle.

Top module: `prst_bank`

## Requirements
- R1: After reset every register and every `rst_lines` bit is 0, `cmd_ready` is 1, and `cmd_done` and `sysrst_req` are 0.
- R2: A bus write to byte offset 0x20, 0x24 or 0x34 loads that register, and `bus_rdata` shows it combinationally. Register 0x20 drives `rst_lines[31:0]`, 0x24 drives `[63:32]` and 0x34 drives `[95:64]`. Any other offset reads 0 and a write to it changes no register.
- R3: A line identifier carries the register offset in `cmd_id[15:8]` and the bit index in `cmd_id[4:0]`. It is valid only when the offset is 0x20, 0x24 or 0x34 and `cmd_id[7:0]` is below 32. An invalid identifier sets `cmd_err` and leaves every register unchanged.
- R4: `cmd_op` 2'b01 sets the addressed bit and 2'b10 clears it. Every other bit of every register is preserved.
- R5: With `cmd_done` high, `cmd_status` gives the addressed bit as it was before the command: 1 means in reset. `cmd_op` 2'b00 and 2'b11 only report and change nothing. An invalid identifier reports 0.
- R6: A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low in the following cycle. `cmd_done` is high for exactly one cycle, starting after the second edge from acceptance, together with `cmd_err`, `cmd_status` and the updated register.
- R7: A bus write to offset 0x14 of the value 0x4 shifted left by n, for n from 1 to 4, raises `sysrst_req[n-1]` for exactly the one cycle after the write edge.
- R8: A write to 0x14 of any other value raises no request. This covers n = 0 (0x4), n of 5 or more (0x80 and up) and words with more than one bit set.
- R9: When a command's update cycle and a bus write hit the same register on the same edge, the register takes the bus data with the command's bit change applied on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 12 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 01 set, 10 clear, 00/11 status |
| cmd_id | input | 16 | Line identifier: offset in [15:8], index in [7:0] |
| cmd_ready | output | 1 | Command port can accept |
| cmd_done | output | 1 | One-cycle reply strobe |
| cmd_err | output | 1 | Identifier rejected |
| cmd_status | output | 1 | Addressed bit before the command |
| rst_lines | output | 96 | Peripheral reset outputs |
| sysrst_req | output | 4 | One-cycle system reset requests |

## Verification
The bench targets identifiers that look nearly valid:
- An index field of exactly 32 would alias to bit 0 in a design that masks the index to five bits.
- The software-reset offset used as a line offset would write a register that does not exist.

It also drives a bus write into the same register in the very cycle a command applies. A design that drops either update would lose the peripheral bit or the bus data. Software-reset words for n of 0 and 5, and a word with two bits set, are checked to fire nothing. A decoder that simply scans for any set bit would raise a request for those.

// File: rtl/prst_pkg.sv
`timescale 1ns/1ps
package prst_pkg;
    localparam int NUM_BANKS = 3;
    localparam int OFS_W     = 12;

    // Byte offset of the write-only system reset trigger
    localparam logic [OFS_W-1:0] SWRST_OFS = 12'h014;

    // Line command encodings; both unlisted codes only report
    typedef enum logic [1:0] {
        OP_PEEK  = 2'b00,
        OP_SET   = 2'b01,
        OP_CLR   = 2'b10,
        OP_PEEK2 = 2'b11
    } cmd_op_e;

    typedef enum logic {
        CS_IDLE  = 1'b0,
        CS_APPLY = 1'b1
    } cmd_state_e;

    // Byte offset of each reset control register
    function automatic logic [OFS_W-1:0] bank_ofs(input int idx);
        case (idx)
            0:       return 12'h020;
            1:       return 12'h024;
            default: return 12'h034;
        endcase
    endfunction
endpackage

// File: rtl/prst_id_decode.sv
`timescale 1ns/1ps
module prst_id_decode
    import prst_pkg::*;
#(
    parameter int ID_W      = 16,
    parameter int IDX_SHIFT = 8,
    parameter int DATA_W    = 32,
    parameter int BIT_W     = $clog2(DATA_W)
) (
    input  logic [ID_W-1:0]      line_id,
    output logic [NUM_BANKS-1:0] bank_sel,
    output logic [BIT_W-1:0]     bit_idx,
    output logic                 id_ok
);
    localparam int FIELD_W = ID_W - IDX_SHIFT;

    logic [FIELD_W-1:0]   ofs_field;
    logic [IDX_SHIFT-1:0] idx_field;
    logic                 idx_ok;

    assign ofs_field = line_id[ID_W-1:IDX_SHIFT];
    assign idx_field = line_id[IDX_SHIFT-1:0];
    assign bit_idx   = idx_field[BIT_W-1:0];
    assign idx_ok    = (32'(idx_field) < DATA_W);

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_match
        assign bank_sel[gi] = idx_ok && (32'(ofs_field) == 32'(bank_ofs(gi)));
    end

    assign id_ok = |bank_sel;
endmodule

// File: rtl/prst_reg_slice.sv
`timescale 1ns/1ps
module prst_reg_slice #(
    parameter int DATA_W = 32,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_hit,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              cmd_hit,
    input  logic [BIT_W-1:0]  cmd_bit,
    input  logic              cmd_set,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = bus_hit ? bus_wdata : q;
        if (cmd_hit) nxt[cmd_bit] = cmd_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R4: a lone command touches only its own bit
    a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !bus_hit) |=>
            (((q ^ $past(q)) & ~(DATA_W'(1) << $past(cmd_bit))) == '0));

    // R4: the addressed bit takes the commanded level
    a_r4_bit_value: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit |=> (q[$past(cmd_bit)] == $past(cmd_set)));

    // R9: a same-cycle bus write keeps its other bits
    a_r9_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && bus_hit) |=>
            (((q ^ $past(bus_wdata)) & ~(DATA_W'(1) << $past(cmd_bit))) == '0));
endmodule

// File: rtl/prst_swrst.sv
`timescale 1ns/1ps
module prst_swrst
    import prst_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int NUM_SYSRST = 4,
    parameter int BASE_BIT   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [NUM_SYSRST-1:0] sysrst_req
);
    logic                  trig_hit;
    logic [NUM_SYSRST-1:0] req_d;

    assign trig_hit = bus_we && (32'(bus_addr) == 32'(SWRST_OFS));

    // request n fires only for the exact word BASE<<n, n = 1..NUM_SYSRST
    for (genvar gn = 1; gn <= NUM_SYSRST; gn++) begin : g_req
        assign req_d[gn-1] = trig_hit && (bus_wdata == (DATA_W'(1) << (BASE_BIT + gn)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sysrst_req <= '0;
        else        sysrst_req <= req_d;
    end

    // R7: each request lasts one cycle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sysrst_req != '0) |=> (sysrst_req == '0));

    // R8: never more than one request at once
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sysrst_req));

    // R7: a request always follows a bus write
    a_r7_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sysrst_req != '0) |-> $past(bus_we));
endmodule

// File: rtl/prst_cmd_fsm.sv
`timescale 1ns/1ps
module prst_cmd_fsm
    import prst_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [ID_W-1:0] cmd_id,
    input  logic            dec_ok,
    input  logic            line_now,
    output logic [ID_W-1:0] held_id,
    output logic            apply_wr,
    output logic            apply_set,
    output logic            apply_en,
    output logic            cmd_ready,
    output logic            cmd_done,
    output logic            cmd_err,
    output logic            cmd_status
);
    cmd_state_e state, state_nxt;
    cmd_op_e    held_op;
    logic       accept;

    assign accept    = cmd_valid && (state == CS_IDLE);
    assign cmd_ready = (state == CS_IDLE);
    assign apply_en  = (state == CS_APPLY);
    assign apply_set = (held_op == OP_SET);
    assign apply_wr  = apply_en && ((held_op == OP_SET) || (held_op == OP_CLR));

    always_comb begin
        state_nxt = state;
        unique case (state)
            CS_IDLE:  if (cmd_valid) state_nxt = CS_APPLY;   // accept
            CS_APPLY: state_nxt = CS_IDLE;                   // retire
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_id    <= '0;
            held_op    <= OP_PEEK;
            cmd_done   <= 1'b0;
            cmd_err    <= 1'b0;
            cmd_status <= 1'b0;
        end else begin
            if (accept) begin
                held_id <= cmd_id;
                held_op <= cmd_op_e'(cmd_op);
            end
            cmd_done <= apply_en;
            if (apply_en) begin
                cmd_err    <= !dec_ok;
                cmd_status <= dec_ok && line_now;
            end
        end
    end

    // R6: reply strobe two edges after acceptance
    a_r6_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> ##1 cmd_done);

    // R6: reply strobe is one cycle wide
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R6: busy in the cycle after acceptance
    a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

// File: rtl/prst_bank.sv
`timescale 1ns/1ps
module prst_bank
    import prst_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int ID_W       = 16,
    parameter int IDX_SHIFT  = 8,
    parameter int NUM_SYSRST = 4,
    parameter int BASE_BIT   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_op,
    input  logic [ID_W-1:0]               cmd_id,
    output logic                          cmd_ready,
    output logic                          cmd_done,
    output logic                          cmd_err,
    output logic                          cmd_status,
    output logic [NUM_BANKS*DATA_W-1:0]   rst_lines,
    output logic [NUM_SYSRST-1:0]         sysrst_req
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [NUM_BANKS-1:0][DATA_W-1:0] q_all;
    logic [NUM_BANKS-1:0]             bank_sel;
    logic [NUM_BANKS-1:0]             bank_bit;
    logic [BIT_W-1:0]                 bit_idx;
    logic [ID_W-1:0]                  held_id;
    logic                             dec_ok, apply_wr, apply_set, apply_en;
    logic                             line_now;

    prst_id_decode #(.ID_W(ID_W), .IDX_SHIFT(IDX_SHIFT), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_dec (
        .line_id(held_id), .bank_sel(bank_sel), .bit_idx(bit_idx), .id_ok(dec_ok)
    );

    prst_cmd_fsm #(.ID_W(ID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .dec_ok(dec_ok), .line_now(line_now), .held_id(held_id), .apply_wr(apply_wr),
        .apply_set(apply_set), .apply_en(apply_en), .cmd_ready(cmd_ready),
        .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_status(cmd_status)
    );

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        logic bus_hit;
        assign bus_hit      = bus_we && (32'(bus_addr) == 32'(bank_ofs(gb)));
        assign bank_bit[gb] = bank_sel[gb] && q_all[gb][bit_idx];

        prst_reg_slice #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_slice (
            .clk(clk), .rst_n(rst_n), .bus_hit(bus_hit), .bus_wdata(bus_wdata),
            .cmd_hit(apply_wr && bank_sel[gb]), .cmd_bit(bit_idx),
            .cmd_set(apply_set), .q(q_all[gb])
        );

        assign rst_lines[gb*DATA_W +: DATA_W] = q_all[gb];
    end

    assign line_now = |bank_bit;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (32'(bus_addr) == 32'(bank_ofs(i))) bus_rdata = q_all[i];
        end
    end

    prst_swrst #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SYSRST(NUM_SYSRST),
                 .BASE_BIT(BASE_BIT)) u_swrst (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sysrst_req(sysrst_req)
    );

    // R3: a rejected identifier leaves the registers untouched
    a_r3_invalid_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_en && !dec_ok && !bus_we) |=> $stable(q_all));

    // R5: report-only commands leave the registers untouched
    a_r5_peek_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_en && !apply_wr && !bus_we) |=> $stable(q_all));
endmodule

// File: tb/prst_bank_tb.sv
`timescale 1ns/1ps
module prst_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [15:0] cmd_id = '0;
    logic        cmd_ready, cmd_done, cmd_err, cmd_status;
    logic [95:0] rst_lines;
    logic [3:0]  sysrst_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prst_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .cmd_status(cmd_status), .rst_lines(rst_lines),
        .sysrst_req(sysrst_req)
    );

    // {op[2], id[16], err, status, read offset[12], read value[32]}
    localparam int NVEC = 13;
    localparam logic [63:0] VEC [NVEC] = '{
        {2'b01, 16'h2005, 1'b0, 1'b0, 12'h020, 32'h0000_0020},
        {2'b01, 16'h201F, 1'b0, 1'b0, 12'h020, 32'h8000_0020},
        {2'b00, 16'h2005, 1'b0, 1'b1, 12'h020, 32'h8000_0020},
        {2'b10, 16'h2005, 1'b0, 1'b1, 12'h020, 32'h8000_0000},
        {2'b01, 16'h2400, 1'b0, 1'b0, 12'h024, 32'h0000_0001},
        {2'b01, 16'h3418, 1'b0, 1'b0, 12'h034, 32'h0100_0000},
        {2'b01, 16'h3419, 1'b0, 1'b0, 12'h034, 32'h0300_0000},
        {2'b01, 16'h2820, 1'b1, 1'b0, 12'h020, 32'h8000_0000},
        {2'b01, 16'h2020, 1'b1, 1'b0, 12'h020, 32'h8000_0000},
        {2'b01, 16'h1402, 1'b1, 1'b0, 12'h034, 32'h0300_0000},
        {2'b10, 16'h3418, 1'b0, 1'b1, 12'h034, 32'h0200_0000},
        {2'b11, 16'h3418, 1'b0, 1'b0, 12'h034, 32'h0200_0000},
        {2'b10, 16'h2400, 1'b0, 1'b1, 12'h024, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive a command; returns at the negedge where the reply is visible
    task automatic run_cmd(input logic [1:0] op, input logic [15:0] id);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, {64'h0, bus_rdata}, {64'h0, exp});
    endtask

    task automatic sw_case(input string tag, input logic [31:0] d, input logic [3:0] exp);
        bus_write(12'h014, d);
        #0.5;
        chk(tag, {92'h0, sysrst_req}, {92'h0, exp});
        @(negedge clk);
        chk({tag, " next"}, {92'h0, sysrst_req}, 96'h0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lines", rst_lines, 96'h0);
        chk("R1 ready", {95'h0, cmd_ready}, 96'h1);
        chk("R1 done", {95'h0, cmd_done}, 96'h0);
        chk("R1 sysrst", {92'h0, sysrst_req}, 96'h0);

        // R3 R4 R5 R6 table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [63:0] v;
            v = VEC[i];
            run_cmd(v[63:62], v[61:46]);
            chk($sformatf("R6 done v%0d", i), {95'h0, cmd_done}, 96'h1);
            chk($sformatf("R3 err v%0d", i), {95'h0, cmd_err}, {95'h0, v[45]});
            chk($sformatf("R5 status v%0d", i), {95'h0, cmd_status}, {95'h0, v[44]});
            read_chk($sformatf("R4 reg v%0d", i), v[43:32], v[31:0]);
            @(negedge clk);
            chk($sformatf("R6 done drop v%0d", i), {95'h0, cmd_done}, 96'h0);
        end
        chk("R2 lines after table", rst_lines, {32'h0200_0000, 32'h0, 32'h8000_0000});

        // R2 bus access
        bus_write(12'h024, 32'hA5A5_0000);
        read_chk("R2 read 0x24", 12'h024, 32'hA5A5_0000);
        chk("R2 lines 0x24", rst_lines, {32'h0200_0000, 32'hA5A5_0000, 32'h8000_0000});
        bus_write(12'h030, 32'hFFFF_FFFF);
        read_chk("R2 unmapped read", 12'h030, 32'h0);
        chk("R2 unmapped write", rst_lines, {32'h0200_0000, 32'hA5A5_0000, 32'h8000_0000});

        // R9 same-cycle merge: command apply edge coincides with bus write
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_id = 16'h2403;
        @(negedge clk);
        cmd_valid = 1'b0;
        bus_we = 1'b1; bus_addr = 12'h024; bus_wdata = 32'h0000_0010;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R9 done", {95'h0, cmd_done}, 96'h1);
        read_chk("R9 merged", 12'h024, 32'h0000_0018);
        // R9 clear merged with bus write of ones
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_id = 16'h3400;
        @(negedge clk);
        cmd_valid = 1'b0;
        bus_we = 1'b1; bus_addr = 12'h034; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_we = 1'b0;
        read_chk("R9 merged clear", 12'h034, 32'hFFFF_FFFE);

        // R7 valid software resets
        sw_case("R7 n1", 32'h0000_0008, 4'b0001);
        sw_case("R7 n2", 32'h0000_0010, 4'b0010);
        sw_case("R7 n4", 32'h0000_0040, 4'b1000);
        // R8 rejected software reset words
        sw_case("R8 n0", 32'h0000_0004, 4'b0000);
        sw_case("R8 n5", 32'h0000_0080, 4'b0000);
        sw_case("R8 two bits", 32'h0000_0018, 4'b0000);
        read_chk("R8 swrst not a bank", 12'h014, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule